// File: doc/BRIEF.md
# Interrupt and Exception Entry Unit

This unit sits beside a CPU control sequencer and owns the interrupt-related part of the processor status word. It watches sixteen interrupt request lines through a per-line mask. It raises a trigger when an unmasked request is pending and interrupts are globally enabled, and it reports the number of the most urgent unmasked line.

When the sequencer accepts an interrupt or raises an exception, the unit records a 5-bit priority code in the status word. The leading bit of that code tells an exception from an interrupt. The unit also registers the entry vector, which depends on a vector-base bit and on whether the event is a user-space translation miss. Two small flag stacks, one for interrupt enable and one for user mode, are pushed on entry and popped on return. The sequencer can also load the whole status word directly. Because the trigger is a combinational function of the registered status, a write or a return that opens interrupts is reflected in the trigger on the very next cycle. A one-instruction enable window is therefore never missed.

Status word layout (28 bits): [15:0] mask (bit i opens line i), [20:16] priority code, [21] enable current, [22] enable previous, [23] enable oldest, [24] user current, [25] user previous, [26] user oldest, [27] vector base select.

Top module: `irq_exc_unit`

## Requirements
- R1: After a synchronous active-low reset, `status` and `vector` are all zeros and `trigger` is 0.
- R2: `trigger` is 1 exactly when some line i has `irq_req[i]` and mask bit i (status bit i) both 1 and the current enable flag (status bit 21) is 1.
- R3: `irq_num` is the highest index i with `irq_req[i]` and mask bit i both set; line 15 ranks highest and line 0 lowest; with no such line `irq_num` is 0.
- R4: A cycle with `take_irq` (and no `take_exc`) writes the priority field [20:16] as 0 followed by the current `irq_num`. It also registers the vector as base + 4.
- R5: A cycle with `take_exc` writes the priority field as 1 followed by `exc_code`. It registers the vector as base + 8 when `exc_umiss` is 1 and base + 4 otherwise.
- R6: The vector base is 0xC0000000 when status bit 27 is 1 and 0xE0000000 when it is 0.
- R7: Taking an event shifts each flag stack toward its oldest slot: oldest ← previous, previous ← current, current ← 0.
- R8: `ret_exc` pops both stacks: current ← previous, previous ← oldest, and oldest is left unchanged.
- R9: `sw_wr` loads all 28 status bits from `sw_wdata`. From the following cycle, `trigger` and `irq_num` follow the new word.
- R10: Same-cycle precedence is `take_exc`, then `take_irq`, then `ret_exc`, then `sw_wr`. Every lower-ranked command in that cycle has no effect on `status` or `vector`.
- R11: `vector` keeps its value in every cycle in which no event is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| irq_req | input | 16 | Interrupt request lines |
| sw_wr | input | 1 | Load the status word |
| sw_wdata | input | 28 | Status word value to load |
| take_irq | input | 1 | Accept the pending interrupt |
| take_exc | input | 1 | Raise an exception |
| exc_code | input | 4 | Exception number |
| exc_umiss | input | 1 | Exception is a user-space translation miss |
| ret_exc | input | 1 | Return from exception |
| trigger | output | 1 | Unmasked request pending while enabled |
| irq_num | output | 4 | Number of the highest unmasked request |
| status | output | 28 | Current status word |
| vector | output | 32 | Entry address of the last taken event |

## Verification
Several commands can arrive in the same cycle: an exception can coincide with an interrupt acceptance, and either can coincide with a return or a status write. The random phase raises each command independently, so such collisions occur often, and a directed case drives all four commands together. The bench model applies the stated precedence and compares the full status word and vector after the edge. Any effect leaking from a losing command shows up as a mismatch.

// File: rtl/irq_exc_pkg.sv
// Shared constants and the command type for the interrupt/exception unit.
// Assumes 32-bit entry addresses.
package irq_exc_pkg;
    localparam logic [31:0] VBASE_LOW  = 32'hE000_0000;
    localparam logic [31:0] VBASE_HIGH = 32'hC000_0000;
    localparam logic [31:0] VOFS_GEN   = 32'd4;
    localparam logic [31:0] VOFS_UMISS = 32'd8;

    typedef enum logic [2:0] {
        CMD_IDLE,
        CMD_WRITE,
        CMD_RET,
        CMD_IRQ,
        CMD_EXC
    } cmd_e;
endpackage

// File: rtl/prio_enc.sv
// Masked priority encoder: reports the highest-index request whose mask is open.
// Assumes N_REQ >= 2; output number is 0 when nothing is pending.
module prio_enc #(
    parameter int N_REQ = 16,
    localparam int NUM_W = $clog2(N_REQ)
) (
    input  logic [N_REQ-1:0] req_i,
    input  logic [N_REQ-1:0] mask_i,
    output logic             any_o,
    output logic [NUM_W-1:0] num_o
);
    logic [N_REQ-1:0] open_req;

    // Scan upward so the highest open request is the last one kept.
    always_comb begin
        open_req = req_i & mask_i;
        any_o    = |open_req;
        num_o    = '0;
        for (int i = 0; i < N_REQ; i++) begin
            if (open_req[i]) num_o = NUM_W'(i);
        end
    end

    // R3: reported line is open and nothing above it is.
    always_comb begin
        if (any_o) begin
            a_r3_highest_open: assert ((open_req >> num_o) == N_REQ'(1));
        end
    end
endmodule

// File: rtl/flag_stack.sv
// Shift stack of single-bit flags; bit 0 is the current flag.
// Push puts 0 on top, pop returns toward the top and keeps the oldest slot.
// Assumes push, pop and load are already mutually exclusive.
module flag_stack #(
    parameter int DEPTH = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic             load,
    input  logic [DEPTH-1:0] load_val,
    output logic [DEPTH-1:0] q
);
    // Update the stack on push, pop or direct load.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (push) q <= {q[DEPTH-2:0], 1'b0};
        else if (pop)  q <= {q[DEPTH-1], q[DEPTH-1:1]};
        else if (load) q <= load_val;
    end

    a_r7_push_shift: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> (q[0] == 1'b0) && (q[DEPTH-1:1] == $past(q[DEPTH-2:0])));

    a_r8_pop_restore: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push) |=> (q[DEPTH-2:0] == $past(q[DEPTH-1:1])) && (q[DEPTH-1] == $past(q[DEPTH-1])));
endmodule

// File: rtl/evt_ctrl.sv
// Command arbitration, priority code and vector formation for one cycle.
// Purely combinational; assumes irq_num is from the same cycle's encoder.
module evt_ctrl
    import irq_exc_pkg::*;
#(
    parameter int NUM_W = 4
) (
    input  logic             take_exc,
    input  logic             take_irq,
    input  logic             ret,
    input  logic             wr,
    input  logic [NUM_W-1:0] exc_code,
    input  logic [NUM_W-1:0] irq_num,
    input  logic             umiss,
    input  logic             vbase_sel,
    output cmd_e             cmd,
    output logic [NUM_W:0]   prio_code,
    output logic [31:0]      vec_new
);
    logic [31:0] base;

    // Pick the winning command by fixed precedence.
    always_comb begin
        if (take_exc)      cmd = CMD_EXC;
        else if (take_irq) cmd = CMD_IRQ;
        else if (ret)      cmd = CMD_RET;
        else if (wr)       cmd = CMD_WRITE;
        else               cmd = CMD_IDLE;
    end

    // Form the priority code and the entry address for a taken event.
    always_comb begin
        base = vbase_sel ? VBASE_HIGH : VBASE_LOW;
        if (cmd == CMD_EXC) begin
            prio_code = {1'b1, exc_code};
            vec_new   = base + (umiss ? VOFS_UMISS : VOFS_GEN);
        end else begin
            prio_code = {1'b0, irq_num};
            vec_new   = base + VOFS_GEN;
        end
    end
endmodule

// File: rtl/irq_exc_unit.sv
// Interrupt and exception entry unit: owns the status word (mask, priority,
// enable/user stacks, vector base), computes trigger and pending number,
// and registers the entry vector. Assumes the sequencer asserts take_irq
// only while it intends to enter the handler.
module irq_exc_unit
    import irq_exc_pkg::*;
#(
    parameter int  N_IRQ = 16,
    parameter int  STK_D = 3,
    localparam int NUM_W = $clog2(N_IRQ),
    localparam int P_LO  = N_IRQ,
    localparam int IE_LO = P_LO + NUM_W + 1,
    localparam int UM_LO = IE_LO + STK_D,
    localparam int VB_B  = UM_LO + STK_D,
    localparam int SW_W  = VB_B + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_IRQ-1:0] irq_req,
    input  logic             sw_wr,
    input  logic [SW_W-1:0]  sw_wdata,
    input  logic             take_irq,
    input  logic             take_exc,
    input  logic [NUM_W-1:0] exc_code,
    input  logic             exc_umiss,
    input  logic             ret_exc,
    output logic             trigger,
    output logic [NUM_W-1:0] irq_num,
    output logic [SW_W-1:0]  status,
    output logic [31:0]      vector
);
    logic [N_IRQ-1:0] mask_q;
    logic [NUM_W:0]   prio_q;
    logic             vb_q;
    logic [31:0]      vec_q;
    logic             any_req;
    cmd_e             cmd;
    logic [NUM_W:0]   prio_code;
    logic [31:0]      vec_new;
    logic             do_take;
    logic [STK_D-1:0] stk_q [2];

    prio_enc #(.N_REQ(N_IRQ)) u_enc (
        .req_i (irq_req),
        .mask_i(mask_q),
        .any_o (any_req),
        .num_o (irq_num)
    );

    evt_ctrl #(.NUM_W(NUM_W)) u_ctrl (
        .take_exc (take_exc),
        .take_irq (take_irq),
        .ret      (ret_exc),
        .wr       (sw_wr),
        .exc_code (exc_code),
        .irq_num  (irq_num),
        .umiss    (exc_umiss),
        .vbase_sel(vb_q),
        .cmd      (cmd),
        .prio_code(prio_code),
        .vec_new  (vec_new)
    );

    assign do_take = (cmd == CMD_EXC) || (cmd == CMD_IRQ);

    // Stack 0 holds interrupt enable, stack 1 holds user mode.
    for (genvar g = 0; g < 2; g++) begin : g_stk
        flag_stack #(.DEPTH(STK_D)) u_stk (
            .clk     (clk),
            .rst_n   (rst_n),
            .push    (do_take),
            .pop     (cmd == CMD_RET),
            .load    (cmd == CMD_WRITE),
            .load_val(sw_wdata[IE_LO + g*STK_D +: STK_D]),
            .q       (stk_q[g])
        );
    end

    // Mask, priority code and vector-base registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            prio_q <= '0;
            vb_q   <= 1'b0;
        end else if (cmd == CMD_WRITE) begin
            mask_q <= sw_wdata[N_IRQ-1:0];
            prio_q <= sw_wdata[P_LO +: NUM_W+1];
            vb_q   <= sw_wdata[VB_B];
        end else if (do_take) begin
            prio_q <= prio_code;
        end
    end

    // Entry vector register, updated only when an event is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)       vec_q <= '0;
        else if (do_take) vec_q <= vec_new;
    end

    // Trigger follows the registered enable flag and open requests.
    always_comb begin
        trigger = any_req & stk_q[0][0];
        status  = {vb_q, stk_q[1], stk_q[0], prio_q, mask_q};
        vector  = vec_q;
    end

    a_r5_exc_lead_one: assert property (@(posedge clk) disable iff (!rst_n)
        take_exc |=> (status[P_LO+NUM_W] == 1'b1) && (status[P_LO +: NUM_W] == $past(exc_code)));

    a_r4_irq_lead_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (take_irq && !take_exc) |=> (status[P_LO +: NUM_W+1] == {1'b0, $past(irq_num)}));

    a_r5_umiss_offset: assert property (@(posedge clk) disable iff (!rst_n)
        (take_exc && exc_umiss) |=> (vector[3:0] == 4'd8));

    a_r11_vector_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take_exc && !take_irq) |=> $stable(vector));

    a_r9_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr && !take_exc && !take_irq && !ret_exc) |=> (status == $past(sw_wdata)));

    a_r2_trigger_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        trigger |-> (status[IE_LO] && ((irq_req & status[N_IRQ-1:0]) != '0)));
endmodule

// File: tb/test_irq_exc_unit.sv
module test_irq_exc_unit;
    localparam int CLK_PERIOD = 10;
    localparam int SW_W = 28;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [15:0]      irq_req;
    logic             sw_wr;
    logic [SW_W-1:0]  sw_wdata;
    logic             take_irq, take_exc, exc_umiss, ret_exc;
    logic [3:0]       exc_code;
    logic             trigger;
    logic [3:0]       irq_num;
    logic [SW_W-1:0]  status;
    logic [31:0]      vector;

    int checks = 0;
    int errors = 0;
    logic [SW_W-1:0] m_st;
    logic [31:0]     m_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_exc_unit i_irq_exc_unit (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sw_wr(sw_wr),
        .sw_wdata(sw_wdata), .take_irq(take_irq), .take_exc(take_exc),
        .exc_code(exc_code), .exc_umiss(exc_umiss), .ret_exc(ret_exc),
        .trigger(trigger), .irq_num(irq_num), .status(status), .vector(vector)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [3:0] f_num(input logic [SW_W-1:0] st, input logic [15:0] rq);
        logic [3:0] n = 4'd0;
        for (int i = 0; i < 16; i++) if (rq[i] && st[i]) n = 4'(i);
        return n;
    endfunction

    function automatic logic f_trig(input logic [SW_W-1:0] st, input logic [15:0] rq);
        return ((rq & st[15:0]) != 16'd0) && st[21];
    endfunction

    function automatic logic [31:0] f_base(input logic [SW_W-1:0] st);
        return st[27] ? 32'hC000_0000 : 32'hE000_0000;
    endfunction

    // Model update for one clock edge using the inputs now driven.
    task automatic model_step();
        if (take_exc || take_irq) begin
            m_vec = f_base(m_st) + ((take_exc && exc_umiss) ? 32'd8 : 32'd4);
            m_st[20:16] = take_exc ? {1'b1, exc_code} : {1'b0, f_num(m_st, irq_req)};
            m_st[23:21] = {m_st[22:21], 1'b0};
            m_st[26:24] = {m_st[25:24], 1'b0};
        end else if (ret_exc) begin
            m_st[23:21] = {m_st[23], m_st[23:22]};
            m_st[26:24] = {m_st[26], m_st[26:25]};
        end else if (sw_wr) begin
            m_st = sw_wdata;
        end
    endtask

    // One cycle: inputs already driven at a falling edge.
    task automatic cycle(input string tag);
        #1;
        chk("R2 trigger", 32'(trigger), 32'(f_trig(m_st, irq_req)));
        chk("R3 irq_num", 32'(irq_num), 32'(f_num(m_st, irq_req)));
        model_step();
        @(posedge clk);
        @(negedge clk);
        chk({tag, " status"}, 32'(status), 32'(m_st));
        chk({tag, " vector"}, vector, m_vec);
    endtask

    task automatic idle_inputs();
        sw_wr = 0; take_irq = 0; take_exc = 0; ret_exc = 0;
        exc_umiss = 0; exc_code = 4'd0; sw_wdata = '0;
    endtask

    initial begin
        #(CLK_PERIOD*100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        idle_inputs();
        irq_req = 16'hFFFF;
        rst_n = 0;
        m_st = '0; m_vec = '0;
        @(negedge clk); @(negedge clk);
        // R1 reset state
        chk("R1 status", 32'(status), 32'd0);
        chk("R1 vector", vector, 32'd0);
        chk("R1 trigger", 32'(trigger), 32'd0);
        rst_n = 1;

        // R9 one-instruction enable window: enable, then disable at once
        irq_req = 16'h0100;
        sw_wr = 1; sw_wdata = 28'h020_FFFF;
        cycle("R9 open");
        sw_wdata = 28'h000_FFFF;
        #1 chk("R9 window trigger", 32'(trigger), 32'd1);
        cycle("R9 close");
        idle_inputs();

        // R3 line 15 beats line 0; R4 interrupt entry, R6 low base
        sw_wr = 1; sw_wdata = 28'h0E0_8001; irq_req = 16'h8001;
        cycle("R9 setup");
        idle_inputs(); take_irq = 1;
        cycle("R4 R7 irq entry");
        idle_inputs();
        chk("R4 vector", vector, 32'hE000_0004);
        chk("R7 enable stack", 32'(status[23:21]), 32'b110);

        // R6 high base, R5 user miss
        sw_wr = 1; sw_wdata = 28'h8A0_0000;
        cycle("R6 setup");
        idle_inputs(); take_exc = 1; exc_code = 4'd9; exc_umiss = 1;
        cycle("R5 R6 exc entry");
        chk("R5 vector", vector, 32'hC000_0008);
        chk("R5 prio", 32'(status[20:16]), 32'h19);
        idle_inputs();

        // R8 pop twice, R11 vector holds
        ret_exc = 1; cycle("R8 pop1"); cycle("R8 pop2");
        chk("R11 vector hold", vector, 32'hC000_0008);
        idle_inputs();

        // R10 all four commands at once
        take_exc = 1; take_irq = 1; ret_exc = 1; sw_wr = 1; sw_wdata = 28'hFFF_FFFF;
        exc_code = 4'd3;
        cycle("R10 collision");
        idle_inputs();
        take_irq = 1; ret_exc = 1; sw_wr = 1; sw_wdata = 28'h123_4567;
        cycle("R10 irq over ret");
        idle_inputs();

        // Random phase
        for (int n = 0; n < 600; n++) begin
            irq_req   = 16'($urandom);
            sw_wr     = ($urandom % 4) == 0;
            sw_wdata  = SW_W'($urandom);
            take_irq  = ($urandom % 6) == 0;
            take_exc  = ($urandom % 8) == 0;
            ret_exc   = ($urandom % 5) == 0;
            exc_code  = 4'($urandom);
            exc_umiss = 1'($urandom);
            cycle("R10 random");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule